// File: doc/BRIEF.md
# Conditional Control-Transfer Sequencer

This unit executes the control-transfer step of three branch-type instructions once the target address has already been computed elsewhere: a conditional jump, a conditional call and a conditional return. A start strobe brings in the operation type, a 4-bit condition selector, the 32-bit target and the current sign, zero, overflow and carry flags. The unit decides whether the transfer is taken, updates its program counter and, for a taken call or return, moves the full 32-bit program counter across a word-wide stack port. When it finishes, it pulses done together with the number of cycles the instruction costs.

The stack port is a valid/ready request channel. The unit raises `stk_valid_o` with a direction (`stk_write_o`), a byte address and, for writes, the data. It holds all of these unchanged until a cycle in which `stk_ready_i` is high, and that cycle is the transfer. Read data on `stk_rdata_i` is taken in the same cycle that `stk_ready_i` is high. The memory side may apply back-pressure for any number of cycles. The stack pointer is internal and grows downward in steps of four bytes.

Top module: `cond_xfer_seq`

## Requirements
- R1: The condition selector `cond_i` is evaluated from S, Z, V and C as follows: 0 never, 1 S^V, 2 (S^V)|Z, 3 C|Z, 4 V, 5 S, 6 Z, 7 C, 8 always, 9 !(S^V), 10 !((S^V)|Z), 11 !(C|Z), 12 !V, 13 !S, 14 !Z, 15 !C.
- R2: A taken jump (`op_i`=0) loads `pc_o` with `target_i`, makes no stack request, and reports 9 cycles.
- R3: A taken call (`op_i`=1) issues one stack write of the current `pc_o` to address SP-4. Once that write is accepted, it sets SP to SP-4, loads `pc_o` with the captured target and reports 12 cycles.
- R4: A taken return (`op_i`=2) issues one stack read at address SP. Once it is accepted, it loads `pc_o` with `stk_rdata_i`, sets SP to SP+4 and reports 12 cycles.
- R5: Any operation whose condition is false leaves `pc_o` and SP unchanged, makes no stack request, and reports 6 cycles.
- R6: Operation code 3 is reserved. It behaves as a not-taken operation whatever the condition.
- R7: While `stk_valid_o` is high and `stk_ready_i` is low, the request, address, direction and write data stay stable. `done_o` rises in the cycle right after acceptance and is never high together with `stk_valid_o`.
- R8: A start strobe that arrives while a stack request is outstanding is ignored.
- R9: After reset, `pc_o` equals the PC reset parameter, SP equals the SP reset parameter, and `stk_valid_o` and `done_o` are low.
- R10: For a jump or a not-taken operation, `done_o` is high in the cycle after the start strobe. A new start is accepted in the same cycle that `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | 0 jump, 1 call, 2 return, 3 reserved |
| cond_i | input | 4 | Condition selector |
| target_i | input | 32 | Computed target address |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| pc_o | output | 32 | Program counter |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 4 | Cycle cost, valid with done_o |
| stk_valid_o | output | 1 | Stack request valid |
| stk_write_o | output | 1 | 1 push (write), 0 pop (read) |
| stk_addr_o | output | 32 | Stack byte address |
| stk_wdata_o | output | 32 | Data to push |
| stk_ready_i | input | 1 | Stack accepts request |
| stk_rdata_i | input | 32 | Popped data, sampled with ready |

## Verification
The assertions assume that `target_i` is held at its start-cycle value for as long as it is sampled, which is at the start edge only. They also assume that the stack side never completes a transfer unless valid is high. The stimulus drives `stk_ready_i` only while it sees `stk_valid_o` high, after a chosen back-pressure delay, and it drives `stk_rdata_i` before the accepting edge. Start strobes injected during an outstanding request are spaced so that they fall strictly inside the busy window.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  typedef enum logic [1:0] {
    OP_JUMP = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2,
    OP_RSVD = 2'd3
  } xfer_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_STACK = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic s;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/cxs_cond_eval.sv
module cxs_cond_eval
  import cxs_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       true_o
);
  logic       lt;
  logic [7:0] base;

  // The upper eight selectors are the negation of the lower eight.
  always_comb begin
    lt      = flags_i.s ^ flags_i.v;
    base[0] = 1'b0;
    base[1] = lt;
    base[2] = lt | flags_i.z;
    base[3] = flags_i.c | flags_i.z;
    base[4] = flags_i.v;
    base[5] = flags_i.s;
    base[6] = flags_i.z;
    base[7] = flags_i.c;
    true_o  = base[cond_i[2:0]] ^ cond_i[3];
  end
endmodule

// File: rtl/cxs_stack_port.sv
module cxs_stack_port #(
  parameter int              W        = 32,
  parameter int              STEP     = 4,
  parameter logic [W-1:0]    SP_RESET = 32'h0000_8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic         stk_valid_o,
  output logic         stk_write_o,
  output logic [W-1:0] stk_addr_o,
  output logic [W-1:0] stk_wdata_o,
  input  logic         stk_ready_i,
  output logic         accept_o
);
  localparam logic [W-1:0] STEP_W = W'(STEP);

  logic [W-1:0] sp_q;
  logic         vld_q;
  logic         wr_q;
  logic [W-1:0] addr_q;
  logic [W-1:0] wdata_q;

  assign accept_o    = vld_q & stk_ready_i;
  assign stk_valid_o = vld_q;
  assign stk_write_o = wr_q;
  assign stk_addr_o  = addr_q;
  assign stk_wdata_o = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q    <= SP_RESET;
      vld_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_o) begin
      vld_q <= 1'b0;
      if (wr_q) sp_q <= addr_q;
      else      sp_q <= sp_q + STEP_W;
    end else if (push_i) begin
      vld_q   <= 1'b1;
      wr_q    <= 1'b1;
      addr_q  <= sp_q - STEP_W;
      wdata_q <= push_data_i;
    end else if (pop_i) begin
      vld_q   <= 1'b1;
      wr_q    <= 1'b0;
      addr_q  <= sp_q;
      wdata_q <= '0;
    end
  end
endmodule

// File: rtl/cond_xfer_seq.sv
module cond_xfer_seq
  import cxs_pkg::*;
#(
  parameter int           W        = 32,
  parameter int           CYC_W    = 4,
  parameter int           SP_STEP  = 4,
  parameter logic [W-1:0] PC_RESET = 32'h0000_1000,
  parameter logic [W-1:0] SP_RESET = 32'h0000_8000,
  parameter int           CYC_JUMP = 9,
  parameter int           CYC_XFER = 12,
  parameter int           CYC_SKIP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [3:0]       cond_i,
  input  logic [W-1:0]     target_i,
  input  logic             flag_s_i,
  input  logic             flag_z_i,
  input  logic             flag_v_i,
  input  logic             flag_c_i,
  output logic [W-1:0]     pc_o,
  output logic             done_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic             stk_valid_o,
  output logic             stk_write_o,
  output logic [W-1:0]     stk_addr_o,
  output logic [W-1:0]     stk_wdata_o,
  input  logic             stk_ready_i,
  input  logic [W-1:0]     stk_rdata_i
);
  localparam logic [CYC_W-1:0] C_JUMP = CYC_W'(CYC_JUMP);
  localparam logic [CYC_W-1:0] C_XFER = CYC_W'(CYC_XFER);
  localparam logic [CYC_W-1:0] C_SKIP = CYC_W'(CYC_SKIP);

  seq_state_e       state_q;
  logic [W-1:0]     pc_q;
  logic [W-1:0]     tgt_q;
  logic             is_call_q;
  logic             done_q;
  logic [CYC_W-1:0] cyc_q;

  flags_t   flg;
  xfer_op_e op;
  logic     cond_true;
  logic     start_ok;
  logic     taken;
  logic     push_req;
  logic     pop_req;
  logic     accept;

  assign flg      = '{s: flag_s_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};
  assign op       = xfer_op_e'(op_i);
  assign start_ok = start_i && (state_q == ST_IDLE);
  assign taken    = cond_true && (op != OP_RSVD);
  assign push_req = start_ok && taken && (op == OP_CALL);
  assign pop_req  = start_ok && taken && (op == OP_RET);

  cxs_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flg),
    .true_o  (cond_true)
  );

  cxs_stack_port #(
    .W        (W),
    .STEP     (SP_STEP),
    .SP_RESET (SP_RESET)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_req),
    .pop_i       (pop_req),
    .push_data_i (pc_q),
    .stk_valid_o (stk_valid_o),
    .stk_write_o (stk_write_o),
    .stk_addr_o  (stk_addr_o),
    .stk_wdata_o (stk_wdata_o),
    .stk_ready_i (stk_ready_i),
    .accept_o    (accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pc_q      <= PC_RESET;
      tgt_q     <= '0;
      is_call_q <= 1'b0;
      done_q    <= 1'b0;
      cyc_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            if (!taken) begin
              done_q <= 1'b1;
              cyc_q  <= C_SKIP;
            end else if (op == OP_JUMP) begin
              pc_q   <= target_i;
              done_q <= 1'b1;
              cyc_q  <= C_JUMP;
            end else begin
              state_q   <= ST_STACK;
              tgt_q     <= target_i;
              is_call_q <= (op == OP_CALL);
            end
          end
        end
        ST_STACK: begin
          if (accept) begin
            pc_q    <= is_call_q ? tgt_q : stk_rdata_i;
            done_q  <= 1'b1;
            cyc_q   <= C_XFER;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign done_o   = done_q;
  assign cycles_o = cyc_q;
endmodule

// File: rtl/cxs_checker.sv
module cxs_checker #(
  parameter int W        = 32,
  parameter int CYC_W    = 4,
  parameter int CYC_JUMP = 9,
  parameter int CYC_XFER = 12,
  parameter int CYC_SKIP = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     target_i,
  input logic [W-1:0]     pc_o,
  input logic             done_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic             stk_valid_o,
  input logic             stk_write_o,
  input logic [W-1:0]     stk_addr_o,
  input logic [W-1:0]     stk_wdata_o,
  input logic             stk_ready_i
);
  localparam logic [CYC_W-1:0] C_JUMP = CYC_W'(CYC_JUMP);
  localparam logic [CYC_W-1:0] C_XFER = CYC_W'(CYC_XFER);
  localparam logic [CYC_W-1:0] C_SKIP = CYC_W'(CYC_SKIP);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid_o && !stk_ready_i |=> stk_valid_o && $stable(stk_addr_o) && $stable(stk_write_o) && $stable(stk_wdata_o)); // R7

  AST_DONE_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !stk_valid_o); // R7

  AST_XFER_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cycles_o == C_XFER |-> $past(stk_valid_o && stk_ready_i)); // R3

  AST_JUMP_LOADS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cycles_o == C_JUMP |-> pc_o == $past(target_i)); // R2

  AST_SKIP_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cycles_o == C_SKIP |-> $stable(pc_o)); // R5

  AST_CYCLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cycles_o == C_JUMP || cycles_o == C_XFER || cycles_o == C_SKIP)); // R10
endmodule

bind cond_xfer_seq cxs_checker #(
  .W        (W),
  .CYC_W    (CYC_W),
  .CYC_JUMP (CYC_JUMP),
  .CYC_XFER (CYC_XFER),
  .CYC_SKIP (CYC_SKIP)
) u_cxs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .target_i    (target_i),
  .pc_o        (pc_o),
  .done_o      (done_o),
  .cycles_o    (cycles_o),
  .stk_valid_o (stk_valid_o),
  .stk_write_o (stk_write_o),
  .stk_addr_o  (stk_addr_o),
  .stk_wdata_o (stk_wdata_o),
  .stk_ready_i (stk_ready_i)
);

// File: tb/cond_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module cond_xfer_seq_tb_top;
  localparam logic [31:0] PC_RST = 32'h0000_1000;
  localparam logic [31:0] SP_RST = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [3:0]  cond = 4'd0;
  logic [31:0] target = '0;
  logic        fs = 1'b0, fz = 1'b0, fv = 1'b0, fc = 1'b0;
  logic        stk_ready = 1'b0;
  logic [31:0] stk_rdata = '0;
  logic [31:0] pc_o, stk_addr, stk_wdata;
  logic        done_o, stk_valid, stk_write;
  logic [3:0]  cycles_o;

  always #5 clk = ~clk;

  cond_xfer_seq #(.PC_RESET(PC_RST), .SP_RESET(SP_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .cond_i(cond),
    .target_i(target), .flag_s_i(fs), .flag_z_i(fz), .flag_v_i(fv), .flag_c_i(fc),
    .pc_o(pc_o), .done_o(done_o), .cycles_o(cycles_o),
    .stk_valid_o(stk_valid), .stk_write_o(stk_write), .stk_addr_o(stk_addr),
    .stk_wdata_o(stk_wdata), .stk_ready_i(stk_ready), .stk_rdata_i(stk_rdata)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R9";
  bit    run_cmp = 1'b0;
  int    rdy_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s %s: actual %h expected %h", phase, tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] e_pc, e_sp, e_addr, e_wd, e_tgt;
  bit          e_busy, e_vld, e_wr, e_done;
  int          e_cyc;

  function automatic bit holds(input logic [3:0] c, input bit s, z, v, cy);
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return s != v;
      4'd2:  return (s != v) || z;
      4'd3:  return cy || z;
      4'd4:  return v;
      4'd5:  return s;
      4'd6:  return z;
      4'd7:  return cy;
      4'd8:  return 1'b1;
      4'd9:  return s == v;
      4'd10: return (s == v) && !z;
      4'd11: return !cy && !z;
      4'd12: return !v;
      4'd13: return !s;
      4'd14: return !z;
      default: return !cy;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_pc = PC_RST; e_sp = SP_RST; e_busy = 0; e_vld = 0; e_wr = 0;
      e_done = 0; e_cyc = 0; e_addr = 0; e_wd = 0; e_tgt = 0;
    end else begin
      e_done = 0;
      if (e_vld && stk_ready) begin
        e_vld = 0; e_busy = 0; e_done = 1; e_cyc = 12;
        if (e_wr) begin e_sp = e_addr; e_pc = e_tgt; end
        else begin e_sp = e_sp + 4; e_pc = stk_rdata; end
      end else if (!e_busy && start) begin
        if (!holds(cond, fs, fz, fv, fc) || op == 2'd3) begin
          e_done = 1; e_cyc = 6;
        end else if (op == 2'd0) begin
          e_pc = target; e_done = 1; e_cyc = 9;
        end else if (op == 2'd1) begin
          e_busy = 1; e_vld = 1; e_wr = 1; e_addr = e_sp - 4; e_wd = e_pc; e_tgt = target;
        end else begin
          e_busy = 1; e_vld = 1; e_wr = 0; e_addr = e_sp;
        end
      end
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(done_o === e_done, "R7/R10", "done", 32'(done_o), 32'(e_done));
      if (e_done) chk(cycles_o === 4'(e_cyc), "R2/R3/R4/R5", "cycles", 32'(cycles_o), 32'(e_cyc));
      chk(pc_o === e_pc, "R2/R3/R4/R5", "pc", pc_o, e_pc);
      chk(stk_valid === e_vld, "R7/R8", "valid", 32'(stk_valid), 32'(e_vld));
      if (e_vld) begin
        chk(stk_write === e_wr, "R3/R4", "dir", 32'(stk_write), 32'(e_wr));
        chk(stk_addr === e_addr, "R3/R4", "addr", stk_addr, e_addr);
        if (e_wr) chk(stk_wdata === e_wd, "R3", "wdata", stk_wdata, e_wd);
      end
    end
  end

  // Stack responder with back-pressure
  always @(negedge clk) begin
    if (stk_valid && rdy_cnt == 0) stk_ready = 1'b1;
    else begin
      stk_ready = 1'b0;
      if (stk_valid) rdy_cnt--;
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [3:0] c, input logic [3:0] f,
                        input logic [31:0] tgt, input logic [31:0] rd, input int dly,
                        input bit inject);
    @(negedge clk);
    start = 1'b1; op = o; cond = c; target = tgt;
    {fs, fz, fv, fc} = f; rdy_cnt = dly; stk_rdata = rd;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 60 && !e_done; n++) begin
      if (inject && n == 1 && stk_valid) begin
        start = 1'b1; op = 2'd0; cond = 4'd8; target = 32'hDEAD_BEEF;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(100000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R9";
    chk(pc_o === PC_RST, "R9", "reset pc", pc_o, PC_RST);
    chk(stk_valid === 1'b0, "R9", "reset valid", 32'(stk_valid), 0);
    chk(done_o === 1'b0, "R9", "reset done", 32'(done_o), 0);
    run_cmp = 1'b1;
    // first call pushes to SP_RST-4
    run_op(2'd1, 4'd8, 4'h0, 32'h0000_2000, 0, 2, 0);

    phase = "R1";
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        run_op(2'd0, 4'(c), 4'(f), {16'hA000, 4'(c), 4'(f), 8'h10}, 0, 0, 0);

    phase = "R2";
    run_op(2'd0, 4'd8, 4'h0, 32'h1234_5670, 0, 0, 0);
    run_op(2'd0, 4'd6, 4'h4, 32'h0000_0004, 0, 0, 0);

    phase = "R3";
    run_op(2'd1, 4'd8, 4'h0, 32'h0000_3000, 0, 0, 0);
    run_op(2'd1, 4'd7, 4'h1, 32'h0000_3100, 0, 1, 0);
    run_op(2'd1, 4'd14, 4'h0, 32'h0000_3200, 0, 4, 0);

    phase = "R4";
    run_op(2'd2, 4'd8, 4'h0, 0, 32'hCAFE_0010, 0, 0);
    run_op(2'd2, 4'd9, 4'h0, 0, 32'hCAFE_0020, 3, 0);

    phase = "R5";
    run_op(2'd1, 4'd0, 4'hF, 32'h5555_0000, 0, 0, 0);
    run_op(2'd2, 4'd6, 4'h0, 0, 32'h6666_0000, 0, 0);
    run_op(2'd0, 4'd15, 4'h1, 32'h7777_0000, 0, 0, 0);

    phase = "R6";
    run_op(2'd3, 4'd8, 4'h0, 32'h8888_0000, 32'h9999_0000, 0, 0);

    phase = "R8";
    run_op(2'd1, 4'd8, 4'h0, 32'h0000_4000, 0, 5, 1);
    run_op(2'd2, 4'd8, 4'h0, 0, 32'h0000_4444, 6, 1);

    phase = "R10";
    for (int i = 0; i < 200; i++)
      run_op(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
             $urandom, $urandom, $urandom_range(0, 3), bit'($urandom_range(0, 1)));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule